// File: doc/BRIEF.md
# SPI Word Master

This block is an SPI master that moves one data word in each direction for every accepted start request. A set of mode inputs chooses the word length (8 to 16 bits, through an encoded size code), the idle level of the serial clock, the edge on which data is sampled, the half-period of the serial clock counted in system clocks, and whether the data output is released between words. The word to send is presented in parallel with the start pulse. The received word appears in parallel together with a one-cycle completion pulse.

The mode inputs are captured when a start is accepted and are held for the whole word. A start is refused when the divider is 0 (engine off) or 1 (not a legal rate). It is also refused when the master-enable input is low or when the size code is one of the reserved values. A refused start leaves every output as it was. Chip-select handling, queuing of several words and inter-word delays are left to the surrounding logic.

Top module: `spi_word_master`

## Requirements
- R1: The 4-bit size code `mode_size` sets the word length N. Code 0000 gives N = 16, and codes 1000 to 1111 give N = 8 to 15 (N = 8 + the low three bits). A word has exactly 2·N serial clock edges.
- R2: A start with a size code in the range 0001 to 0111 is ignored. Busy stays low, no done pulse is produced, the serial clock does not toggle and the received word keeps its value.
- R3: A start is ignored in the same way when `mode_div` is 0, when `mode_div` is 1, or when `mode_master` is 0.
- R4: While idle, `sclk` equals `mode_cpol`: low when it is 0, high when it is 1. After the last edge of a word, `sclk` is back at that idle level.
- R5: With `mode_cpha` = 0, the first bit is on `sdo` before the first edge. Input is sampled on leading edges (the first, third, … edge of the word) and `sdo` changes on trailing edges.
- R6: With `mode_cpha` = 1, the first bit is also on `sdo` before the first edge. `sdo` moves to the next bit on every leading edge after the first, and input is sampled on trailing edges.
- R7: Bits go out most significant first, starting at bit N−1 of `tx_word`. `rx_word` holds the N received bits right-aligned, first received bit at position N−1, with bits N and above cleared.
- R8: Every serial clock level lasts exactly `mode_div` system clocks, counted from the accepting clock edge. Busy is high for exactly 2·N·`mode_div` cycles per word.
- R9: `done` is high for exactly one cycle per word, in the cycle in which busy has just fallen. `rx_word` changes only together with `done`.
- R10: `sdo_oe` is 1 throughout a word. While idle it equals the inverse of `mode_float`, so a set `mode_float` releases the output between words.
- R11: While busy, a start pulse and changes to the mode inputs or `tx_word` have no effect on the word in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to transfer one word |
| mode_master | input | 1 | Master enable; must be 1 for a start to be accepted |
| mode_float | input | 1 | 1 releases `sdo` (oe low) between words |
| mode_size | input | 4 | Encoded word length |
| mode_cpol | input | 1 | Idle level of `sclk` |
| mode_cpha | input | 1 | Sampling edge select |
| mode_div | input | 8 | System clocks per serial clock level |
| tx_word | input | 16 | Word to send, right-aligned |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| busy | output | 1 | A word is in progress |
| done | output | 1 | One-cycle pulse at the end of a word |
| rx_word | output | 16 | Last received word, right-aligned |

## Verification
A wrong divider count shows up at the first serial clock edge. That edge arrives a multiple of system clocks away from `mode_div` after the accepting edge, so the bench measures the spacing of every edge. A wrong edge counter or decoded length shows up only at the end of the word: there are too many or too few edges, the busy time is off by a multiple of `mode_div`, or `sclk` rests at the wrong level. A shifter that is misaligned or shifts on the wrong edge corrupts the first bit that a slave model captures from `sdo`. It also leaves a shifted or uncleared value in `rx_word` at the done pulse.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

    localparam int MAX_W  = 16;
    localparam int DIV_W  = 8;
    localparam int SIZE_W = 4;
    localparam int CNT_W  = $clog2(MAX_W + 1);
    localparam int EDGE_W = CNT_W + 1;

    typedef logic [CNT_W-1:0] nbits_t;

    typedef struct packed {
        nbits_t           nbits;
        logic             cpol;
        logic             cpha;
        logic [DIV_W-1:0] div;
    } xfer_cfg_t;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } eng_state_t;

    // Size code to word length; 0 marks a reserved code.
    function automatic nbits_t size_to_bits(input logic [SIZE_W-1:0] code);
        if (code == '0)
            return nbits_t'(MAX_W);
        else if (code[SIZE_W-1])
            return nbits_t'(8) + nbits_t'(code[SIZE_W-2:0]);
        else
            return '0;
    endfunction

endpackage

// File: rtl/spi_cfg_decode.sv
module spi_cfg_decode
    import spi_word_pkg::*;
(
    input  logic              mode_master,
    input  logic [SIZE_W-1:0] mode_size,
    input  logic              mode_cpol,
    input  logic              mode_cpha,
    input  logic [DIV_W-1:0]  mode_div,
    output xfer_cfg_t         cfg,
    output logic              cfg_ok
);
    nbits_t n;

    always_comb begin
        n          = size_to_bits(mode_size);
        cfg.nbits  = n;
        cfg.cpol   = mode_cpol;
        cfg.cpha   = mode_cpha;
        cfg.div    = mode_div;
        cfg_ok     = mode_master && (mode_div >= DIV_W'(2)) && (n != '0);
    end
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_word_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == (div - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_word_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  nbits_t           load_nbits,
    input  logic [MAX_W-1:0] load_word,
    input  nbits_t           run_nbits,
    input  logic             run_cpha,
    input  logic             tick,
    input  logic             sdi,
    output logic             sdo_bit,
    output logic             sclk_ph,
    output logic             last_tick,
    output logic [MAX_W-1:0] rx_final
);
    logic [MAX_W-1:0]  tx_sh;
    logic [MAX_W-1:0]  rx_sh;
    logic [EDGE_W-1:0] edge_q;
    logic              ph_q;

    logic              leading;
    logic              last_edge;
    logic              sample_now;
    logic              shift_now;
    logic [EDGE_W-1:0] last_idx;
    logic [MAX_W-1:0]  rx_next;
    nbits_t            pad;

    always_comb begin
        last_idx   = {run_nbits, 1'b0} - 1'b1;
        leading    = ~edge_q[0];
        last_edge  = (edge_q == last_idx);
        sample_now = tick && (run_cpha ? ~leading : leading);
        shift_now  = tick && (run_cpha ? (leading && (edge_q != '0))
                                       : (~leading && ~last_edge));
        rx_next    = {rx_sh[MAX_W-2:0], sdi};
        rx_final   = sample_now ? rx_next : rx_sh;
        last_tick  = tick && last_edge;
        pad        = nbits_t'(MAX_W) - load_nbits;
    end

    assign sdo_bit = tx_sh[MAX_W-1];
    assign sclk_ph = ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh  <= '0;
            rx_sh  <= '0;
            edge_q <= '0;
            ph_q   <= 1'b0;
        end else if (load) begin
            tx_sh  <= load_word << pad;
            rx_sh  <= '0;
            edge_q <= '0;
            ph_q   <= 1'b0;
        end else begin
            if (tick) begin
                edge_q <= edge_q + 1'b1;
                ph_q   <= ~ph_q;
            end
            if (shift_now)
                tx_sh <= tx_sh << 1;
            if (sample_now)
                rx_sh <= rx_next;
        end
    end
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spi_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode_master,
    input  logic              mode_float,
    input  logic [SIZE_W-1:0] mode_size,
    input  logic              mode_cpol,
    input  logic              mode_cpha,
    input  logic [DIV_W-1:0]  mode_div,
    input  logic [MAX_W-1:0]  tx_word,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              busy,
    output logic              done,
    output logic [MAX_W-1:0]  rx_word
);
    eng_state_t       state_q;
    xfer_cfg_t        cfg_live;
    xfer_cfg_t        cfg_q;
    logic             cfg_ok;
    logic             accept;
    logic             tick;
    logic             last_tick;
    logic             sclk_ph;
    logic             sdo_bit;
    logic             done_q;
    logic [MAX_W-1:0] rx_q;
    logic [MAX_W-1:0] rx_final;
    logic             running;

    spi_cfg_decode u_dec (
        .mode_master (mode_master),
        .mode_size   (mode_size),
        .mode_cpol   (mode_cpol),
        .mode_cpha   (mode_cpha),
        .mode_div    (mode_div),
        .cfg         (cfg_live),
        .cfg_ok      (cfg_ok)
    );

    assign running = (state_q == ST_RUN);
    assign accept  = (state_q == ST_IDLE) && start && cfg_ok;

    spi_rate_gen u_rate (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .div  (cfg_q.div),
        .tick (tick)
    );

    spi_shift_core u_core (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .load_nbits (cfg_live.nbits),
        .load_word  (tx_word),
        .run_nbits  (cfg_q.nbits),
        .run_cpha   (cfg_q.cpha),
        .tick       (tick),
        .sdi        (sdi),
        .sdo_bit    (sdo_bit),
        .sclk_ph    (sclk_ph),
        .last_tick  (last_tick),
        .rx_final   (rx_final)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            done_q  <= 1'b0;
            rx_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_RUN;
                        cfg_q   <= cfg_live;
                    end
                end
                ST_RUN: begin
                    if (last_tick) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        rx_q    <= rx_final;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sclk    = running ? (cfg_q.cpol ^ sclk_ph) : mode_cpol;
    assign sdo     = sdo_bit;
    assign sdo_oe  = running | ~mode_float;
    assign busy    = running;
    assign done    = done_q;
    assign rx_word = rx_q;
endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk
    import spi_word_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mode_master,
    input logic              mode_float,
    input logic [SIZE_W-1:0] mode_size,
    input logic              mode_cpol,
    input logic              mode_cpha,
    input logic [DIV_W-1:0]  mode_div,
    input logic [MAX_W-1:0]  tx_word,
    input logic              sdi,
    input logic              sclk,
    input logic              sdo,
    input logic              sdo_oe,
    input logic              busy,
    input logic              done,
    input logic [MAX_W-1:0]  rx_word
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r9_rx_moves_with_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_word) |-> done);

    a_r3_div_zero_refused: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && mode_div == '0) |=> !busy);

    a_r2_reserved_refused: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && mode_size != '0 && !mode_size[SIZE_W-1]) |=> !busy);

    a_r10_oe_during_word: assert property (@(posedge clk) disable iff (rst)
        busy |-> sdo_oe);

    a_r4_idle_clock_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && $stable(mode_cpol)) |-> $stable(sclk));
endmodule

bind spi_word_master spi_word_master_chk u_chk (.*);

// File: tb/sim_spi_word_master.sv
`timescale 1ns/1ps
module sim_spi_word_master;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        mode_master;
    logic        mode_float;
    logic [3:0]  mode_size;
    logic        mode_cpol;
    logic        mode_cpha;
    logic [7:0]  mode_div;
    logic [15:0] tx_word;
    logic        sdi;
    logic        sclk;
    logic        sdo;
    logic        sdo_oe;
    logic        busy;
    logic        done;
    logic [15:0] rx_word;

    int n_chk = 0;
    int n_fail = 0;

    // slave model state
    bit          in_xfer = 1'b0;
    bit          cur_cpha;
    int          exp_div;
    int          slv_idx;
    int          slv_edges;
    int          spacing_err;
    int          sclk_toggles = 0;
    logic [15:0] slv_word;
    logic [15:0] slv_rx;
    longint      last_t;

    always #2 clk = ~clk;

    spi_word_master u0 (
        .clk(clk), .rst(rst), .start(start), .mode_master(mode_master),
        .mode_float(mode_float), .mode_size(mode_size), .mode_cpol(mode_cpol),
        .mode_cpha(mode_cpha), .mode_div(mode_div), .tx_word(tx_word),
        .sdi(sdi), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy),
        .done(done), .rx_word(rx_word)
    );

    always @(sclk) begin
        bit lead;
        bit chg;
        sclk_toggles++;
        if (in_xfer) begin
            lead = (slv_edges % 2 == 0);
            if (($time - last_t) != longint'(exp_div * 4)) spacing_err++;
            last_t = $time;
            if (cur_cpha ? !lead : lead) slv_rx = {slv_rx[14:0], sdo};
            chg = cur_cpha ? (lead && slv_edges > 0) : !lead;
            if (chg) begin
                slv_idx--;
                if (slv_idx >= 0) sdi = slv_word[slv_idx];
            end
            slv_edges++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bits_of(input logic [3:0] code);
        return (code == 4'b0000) ? 16 : 8 + int'(code[2:0]);
    endfunction

    function automatic logic [15:0] mask_of(input int n);
        logic [15:0] m;
        for (int i = 0; i < 16; i++) m[i] = (i < n);
        return m;
    endfunction

    // One full word; disturb pulses start and changes modes mid-word (R11)
    task automatic run_xfer(input logic [3:0] code, input bit cpol, input bit cpha,
                            input int div, input logic [15:0] tx,
                            input logic [15:0] sw, input bit flt,
                            input bit disturb, input string req);
        int n;
        int bc;
        int oe_bad;
        int it;
        logic [15:0] m;
        n = bits_of(code);
        m = mask_of(n);
        @(negedge clk);
        mode_master = 1'b1; mode_float = flt; mode_size = code;
        mode_cpol = cpol; mode_cpha = cpha; mode_div = 8'(div); tx_word = tx;
        @(negedge clk);
        chk(sclk == cpol, "R4", "idle sclk", sclk, cpol);
        slv_word = sw; slv_idx = n - 1; sdi = sw[n-1]; slv_edges = 0; slv_rx = '0;
        cur_cpha = cpha; exp_div = div; spacing_err = 0;
        last_t = $time + 2;
        in_xfer = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bc = 0; oe_bad = 0; it = 0;
        while (!done && it < 20000) begin
            if (busy) bc++;
            if (busy && !sdo_oe) oe_bad++;
            if (disturb && it == 5) begin
                start = 1'b1; mode_size = 4'b0000; mode_div = 8'd4;
                mode_cpha = ~cpha; tx_word = ~tx;
            end
            if (disturb && it == 6) start = 1'b0;
            @(negedge clk);
            it++;
        end
        in_xfer = 1'b0;
        chk(done == 1'b1, "R9", "done seen", done, 1);
        chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
        chk(slv_edges == 2 * n, "R1", "edge count", slv_edges, 2 * n);
        chk(bc == 2 * n * div, "R8", "busy cycles", bc, 2 * n * div);
        chk(spacing_err == 0, "R8", "edge spacing errors", spacing_err, 0);
        chk(rx_word == (sw & m), "R7", "rx_word", rx_word, sw & m);
        chk((slv_rx & m) == (tx & m), cpha ? "R6" : "R5", "slave got", slv_rx & m, tx & m);
        chk(sclk == cpol, "R4", "sclk after word", sclk, cpol);
        chk(oe_bad == 0, "R10", "oe low in word", oe_bad, 0);
        if (disturb) chk(slv_edges == 2 * n && rx_word == (sw & m), "R11",
                         "word unaffected", rx_word, sw & m);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", done, 0);
        chk(busy == 1'b0, "R11", "extra start not queued", busy, 0);
        chk(sdo_oe == !flt, "R10", "idle oe", sdo_oe, !flt);
        $display("  %s: %0d-bit cpol=%0d cpha=%0d div=%0d done", req, n, cpol, cpha, div);
    endtask

    task automatic refused(input logic [3:0] code, input int div, input bit mst,
                           input string req);
        int t0;
        logic [15:0] r0;
        int seen_busy;
        int seen_done;
        @(negedge clk);
        mode_master = mst; mode_size = code; mode_div = 8'(div);
        mode_cpol = 1'b0; mode_cpha = 1'b0; tx_word = 16'hFFFF;
        @(negedge clk);
        t0 = sclk_toggles; r0 = rx_word; seen_busy = 0; seen_done = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (busy) seen_busy++;
            if (done) seen_done++;
            @(negedge clk);
        end
        chk(seen_busy == 0, req, "busy on refused start", seen_busy, 0);
        chk(seen_done == 0, req, "done on refused start", seen_done, 0);
        chk(sclk_toggles == t0, req, "sclk toggles", sclk_toggles - t0, 0);
        chk(rx_word == r0, req, "rx_word kept", rx_word, r0);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0, "R9", "reset busy", busy, 0);
        chk(done == 1'b0, "R9", "reset done", done, 0);
        chk(rx_word == 16'h0, "R7", "reset rx_word", rx_word, 0);
        chk(sclk == 1'b0, "R4", "reset sclk", sclk, 0);
        chk(sdo_oe == 1'b1, "R10", "reset oe", sdo_oe, 1);
    endtask

    task automatic t_float_idle;
        @(negedge clk);
        mode_float = 1'b1;
        @(negedge clk);
        chk(sdo_oe == 1'b0, "R10", "released idle", sdo_oe, 0);
        run_xfer(4'b1011, 1'b1, 1'b0, 3, 16'h05A5, 16'hF3C3, 1'b1, 1'b0, "R10 float");
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mode_master = 1'b1; mode_float = 1'b0;
        mode_size = 4'b1000; mode_cpol = 1'b0; mode_cpha = 1'b0; mode_div = 8'd2;
        tx_word = '0; sdi = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_xfer(4'b1000, 1'b0, 1'b0, 2, 16'h00A5, 16'hFF3C, 1'b0, 1'b0, "R5 basic");
        run_xfer(4'b1100, 1'b0, 1'b0, 3, 16'h0ABC, 16'hE5A1, 1'b0, 1'b0, "R5 mode0");
        run_xfer(4'b1100, 1'b0, 1'b1, 3, 16'h0C35, 16'h1234, 1'b0, 1'b0, "R6 mode1");
        run_xfer(4'b1100, 1'b1, 1'b0, 3, 16'h0F0F, 16'h8421, 1'b0, 1'b0, "R4 mode2");
        run_xfer(4'b1100, 1'b1, 1'b1, 3, 16'h0963, 16'hBEEF, 1'b0, 1'b0, "R6 mode3");
        run_xfer(4'b0000, 1'b0, 1'b1, 2, 16'hC3A5, 16'h5AC3, 1'b0, 1'b0, "R1 sixteen");
        for (int c = 9; c < 16; c++)
            run_xfer(4'(c), 1'b0, 1'b0, 2, 16'h6D2B, 16'hA9F7, 1'b0, 1'b0, "R1 sizes");
        for (int c = 1; c < 8; c++) refused(4'(c), 2, 1'b1, "R2");
        refused(4'b1000, 0, 1'b1, "R3");
        refused(4'b1000, 1, 1'b1, "R3");
        refused(4'b1000, 2, 1'b0, "R3");
        t_float_idle();
        run_xfer(4'b0000, 1'b1, 1'b0, 255, 16'h8001, 16'h7FFE, 1'b0, 1'b0, "R8 slow");
        run_xfer(4'b1000, 1'b0, 1'b0, 2, 16'h0096, 16'h0069, 1'b0, 1'b1, "R11 busy");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule